// File: doc/BRIEF.md
# Counter-Mode Cipher Sequencer

This block drives an external 128-bit block cipher core to run counter chaining. Software loads a key and a 128-bit counter block, selects counter chaining in a small control register, and sets the enable bit. The sequencer sends the current counter block and the key to the core over a request/acknowledge handshake. It keeps the returned keystream and waits for one data block on a valid/ready input stream. It XORs the two, presents the result on a valid/ready output stream, advances the counter and clears the enable bit by itself. Encryption and decryption run the same path.

The last block of a message can be short. A valid-byte count of 1 to 16 comes with each input block, and byte 0 is the most significant byte (bits 127:120). Input bytes at or beyond the count are treated as zero, and the matching output bytes are forced to zero. The counter can be read at any time. To suspend a message, software saves the counter. To resume it, software writes that value back while the block is idle.

Back-pressure rules: `din_ready` is high only once the keystream for the current block is held and the output register is empty. A block is taken on a cycle with both `din_valid` and `din_ready` high. `dout_valid` stays high, with `dout_data` unchanged, until a cycle with `dout_ready` high. While a result is waiting, a new enable is refused.

Top module: `ctr_cipher_seq`

## Requirements
- R1: Writes to the chaining field, operating field, key and counter are ignored while `en` is 1. A control write that tries to clear `en` while it is 1 is also ignored.
- R2: A control write with enable set makes `en` 1 only if the chaining field is binary 10 and the operating field is not binary 01. Otherwise `en` stays 0 and no core request is made.
- R3: One cycle after `en` rises, `core_req` goes high with `core_blk` equal to the counter and `core_key` equal to the key. `core_req` and `core_blk` hold steady until `core_ack` is seen.
- R4: `din_ready` rises only after `core_ack` has delivered the keystream. The accepted block gives `dout_data` equal to `din_data` XOR keystream, so feeding a result back in with the same counter restores the original data.
- R5: `busy` is high from the cycle after `en` rises until the result is latched. In the cycle after the block is accepted, `done` is high for exactly one cycle, `en` is 0 and `busy` is 0.
- R6: After each block, the low CNT_W bits of the counter increase by one modulo 2^CNT_W, and the upper bits are unchanged.
- R7: For a valid-byte count n below 16, output bytes n..15 are zero (byte k is bits 127-8k down to 120-8k). Bytes below n follow R4.
- R8: `dout_valid` and `dout_data` hold steady until `dout_ready`. While `dout_valid` is high, `din_ready` is 0 and enable writes are refused.
- R9: `ctr_cur` shows the counter at all times. Writing a saved counter back while idle resumes the keystream from that block.
- R10: After reset, `en`, `busy`, `done`, `dout_valid` and `core_req` are 0, and the key and counter are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_en | input | 1 | Enable bit written with the control register |
| ctl_chain | input | 2 | Chaining field (10 selects counter mode) |
| ctl_op | input | 2 | Operating field (01 is refused) |
| key_we | input | 1 | Key write strobe |
| key_in | input | BLK_W | Key value |
| ctr_we | input | 1 | Counter write strobe |
| ctr_in | input | BLK_W | Counter value |
| en | output | 1 | Enable bit; clears itself after each block |
| cfg_chain | output | 2 | Stored chaining field |
| cfg_op | output | 2 | Stored operating field |
| busy | output | 1 | A block is in progress |
| done | output | 1 | One-cycle pulse when a result is latched |
| ctr_cur | output | BLK_W | Current counter block |
| din_valid | input | 1 | Input block valid |
| din_ready | output | 1 | Input block accepted when high with valid |
| din_data | input | BLK_W | Input block, byte 0 in the top bits |
| din_nbytes | input | $clog2(BLK_W/8+1) | Valid bytes in this block, 1 to 16 |
| dout_valid | output | 1 | Output block valid |
| dout_ready | input | 1 | Downstream takes the output block |
| dout_data | output | BLK_W | Output block |
| core_req | output | 1 | Request to the cipher core |
| core_ack | input | 1 | Cipher core result valid |
| core_key | output | BLK_W | Key to the core |
| core_blk | output | BLK_W | Counter block to the core |
| core_res | input | BLK_W | Encrypted counter (keystream) |

## Verification
The bench builds the block with BLK_W of 128 and CNT_W of 16. With that setting, the edge between the counting field and the fixed field sits inside a word. A counter whose low half-word is all ones must wrap to zero and leave bits 127:16 unchanged, and 65,536 blocks are not needed to reach the wrap. The stand-in core answers three cycles after each request, so the hold rules on the request side and on both streams are exercised over several stalled cycles.

// File: rtl/ctr_seq_pkg.sv
package ctr_seq_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;

  localparam logic [1:0] CHAIN_COUNTER = 2'b10;
  localparam logic [1:0] OPMODE_BAD    = 2'b01;
endpackage

// File: rtl/ctr_cfg_regs.sv
module ctr_cfg_regs #(
  parameter int BLK_W = 128,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock,
  input  logic             ctl_we,
  input  logic [1:0]       ctl_chain,
  input  logic [1:0]       ctl_op,
  input  logic             key_we,
  input  logic [BLK_W-1:0] key_in,
  input  logic             ctr_we,
  input  logic [BLK_W-1:0] ctr_in,
  input  logic             adv,
  output logic [1:0]       chain_q,
  output logic [1:0]       op_q,
  output logic [BLK_W-1:0] key_q,
  output logic [BLK_W-1:0] ctr_q
);
  logic [BLK_W-1:0] ctr_step;

  generate
    if (CNT_W >= BLK_W) begin : g_full
      assign ctr_step = ctr_q + BLK_W'(1);
    end else begin : g_split
      assign ctr_step = {ctr_q[BLK_W-1:CNT_W], ctr_q[CNT_W-1:0] + CNT_W'(1)};

      p_upper_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> $stable(ctr_q[BLK_W-1:CNT_W]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
      op_q    <= '0;
      key_q   <= '0;
      ctr_q   <= '0;
    end else begin
      if (ctl_we && !lock) begin
        chain_q <= ctl_chain;
        op_q    <= ctl_op;
      end
      if (key_we && !lock) key_q <= key_in;
      if (adv) ctr_q <= ctr_step;
      else if (ctr_we && !lock) ctr_q <= ctr_in;
    end
  end

  p_ctr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> ctr_q[CNT_W-1:0] == $past(ctr_q[CNT_W-1:0]) + CNT_W'(1));

  p_ctr_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !adv) |=> $stable(ctr_q));

  p_key_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(key_q));
endmodule

// File: rtl/ctr_core_port.sv
module ctr_core_port #(
  parameter int BLK_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             consume,
  input  logic [BLK_W-1:0] ctr_q,
  input  logic [BLK_W-1:0] key_q,
  output logic             core_req,
  input  logic             core_ack,
  output logic [BLK_W-1:0] core_key,
  output logic [BLK_W-1:0] core_blk,
  input  logic [BLK_W-1:0] core_res,
  output logic             ks_valid,
  output logic [BLK_W-1:0] ks_q
);
  assign core_key = key_q;
  assign core_blk = ctr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_req <= 1'b0;
      ks_valid <= 1'b0;
      ks_q     <= '0;
    end else begin
      if (start) core_req <= 1'b1;
      else if (core_ack) core_req <= 1'b0;

      if (core_req && core_ack) begin
        ks_q     <= core_res;
        ks_valid <= 1'b1;
      end else if (consume) begin
        ks_valid <= 1'b0;
      end
    end
  end

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req && !core_ack) |=> (core_req && $stable(core_blk) && $stable(core_key)));

  p_ks_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ks_valid) |-> $past(core_ack));
endmodule

// File: rtl/ctr_xor_pad.sv
module ctr_xor_pad #(
  parameter int BLK_W = 128,
  parameter int CW    = 5
) (
  input  logic [BLK_W-1:0] din,
  input  logic [BLK_W-1:0] ks,
  input  logic [CW-1:0]    nbytes,
  output logic [BLK_W-1:0] res
);
  localparam int NB = BLK_W / 8;

  generate
    for (genvar i = 0; i < NB; i++) begin : g_byte
      logic [7:0] mixed;
      assign mixed = din[BLK_W-1-8*i -: 8] ^ ks[BLK_W-1-8*i -: 8];
      assign res[BLK_W-1-8*i -: 8] = (nbytes > CW'(i)) ? mixed : 8'h00;
    end
  endgenerate
endmodule

// File: rtl/ctr_cipher_seq.sv
module ctr_cipher_seq
  import ctr_seq_pkg::*;
#(
  parameter int BLK_W = 128,
  parameter int CNT_W = 32,
  localparam int NB   = BLK_W / 8,
  localparam int CW   = $clog2(NB + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ctl_en,
  input  logic [1:0]       ctl_chain,
  input  logic [1:0]       ctl_op,
  input  logic             key_we,
  input  logic [BLK_W-1:0] key_in,
  input  logic             ctr_we,
  input  logic [BLK_W-1:0] ctr_in,
  output logic             en,
  output logic [1:0]       cfg_chain,
  output logic [1:0]       cfg_op,
  output logic             busy,
  output logic             done,
  output logic [BLK_W-1:0] ctr_cur,
  input  logic             din_valid,
  output logic             din_ready,
  input  logic [BLK_W-1:0] din_data,
  input  logic [CW-1:0]    din_nbytes,
  output logic             dout_valid,
  input  logic             dout_ready,
  output logic [BLK_W-1:0] dout_data,
  output logic             core_req,
  input  logic             core_ack,
  output logic [BLK_W-1:0] core_key,
  output logic [BLK_W-1:0] core_blk,
  input  logic [BLK_W-1:0] core_res
);
  seq_state_t       state;
  logic             start, fin, ks_valid, cfg_ok;
  logic [BLK_W-1:0] key_q, ks_q, mixed;

  ctr_cfg_regs #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .lock(en),
    .ctl_we(ctl_we), .ctl_chain(ctl_chain), .ctl_op(ctl_op),
    .key_we(key_we), .key_in(key_in), .ctr_we(ctr_we), .ctr_in(ctr_in),
    .adv(fin), .chain_q(cfg_chain), .op_q(cfg_op), .key_q(key_q), .ctr_q(ctr_cur)
  );

  ctr_core_port #(.BLK_W(BLK_W)) u_port (
    .clk(clk), .rst_n(rst_n), .start(start), .consume(fin),
    .ctr_q(ctr_cur), .key_q(key_q),
    .core_req(core_req), .core_ack(core_ack), .core_key(core_key),
    .core_blk(core_blk), .core_res(core_res),
    .ks_valid(ks_valid), .ks_q(ks_q)
  );

  ctr_xor_pad #(.BLK_W(BLK_W), .CW(CW)) u_mix (
    .din(din_data), .ks(ks_q), .nbytes(din_nbytes), .res(mixed)
  );

  assign cfg_ok    = (ctl_chain == CHAIN_COUNTER) && (ctl_op != OPMODE_BAD);
  assign start     = (state == SEQ_IDLE) && en;
  assign din_ready = (state == SEQ_RUN) && ks_valid && !dout_valid;
  assign fin       = din_valid && din_ready;
  assign busy      = (state == SEQ_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en         <= 1'b0;
      state      <= SEQ_IDLE;
      done       <= 1'b0;
      dout_valid <= 1'b0;
      dout_data  <= '0;
    end else begin
      done <= fin;
      if (fin) en <= 1'b0;
      else if (ctl_we && !en && !dout_valid) en <= ctl_en && cfg_ok;

      if (start) state <= SEQ_RUN;
      else if (fin) state <= SEQ_IDLE;

      if (fin) begin
        dout_data  <= mixed;
        dout_valid <= 1'b1;
      end else if (dout_valid && dout_ready) begin
        dout_valid <= 1'b0;
      end
    end
  end

  p_bad_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !en && ctl_op == OPMODE_BAD) |=> !en);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!en && !busy && dout_valid));

  p_req_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_req |-> busy);

  p_ready_after_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
    din_ready |-> !core_req);

  p_dout_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data)));

  p_no_enable_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !en) |=> !en);
endmodule

// File: tb/ctr_cipher_seq_bench.sv
module ctr_cipher_seq_bench;
  localparam int CLK_P = 10;
  localparam int BW    = 128;
  localparam int CNTW  = 16;
  localparam int NBW   = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0, ctl_en = 0, key_we = 0, ctr_we = 0;
  logic [1:0] ctl_chain = 0, ctl_op = 0;
  logic [BW-1:0] key_in = 0, ctr_in = 0, din_data = 0;
  logic din_valid = 0, dout_ready = 0;
  logic [NBW-1:0] din_nbytes = 0;
  logic en, busy, done, din_ready, dout_valid, core_req;
  logic [1:0] cfg_chain, cfg_op;
  logic [BW-1:0] ctr_cur, dout_data, core_key, core_blk;
  logic core_ack;
  logic [BW-1:0] core_res;
  logic [1:0] dly;

  int checks = 0, errors = 0, cycles = 0;
  logic [BW-1:0] key_m, ctr_m;

  ctr_cipher_seq #(.BLK_W(BW), .CNT_W(CNTW)) u_ctr_cipher_seq (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_en(ctl_en),
    .ctl_chain(ctl_chain), .ctl_op(ctl_op), .key_we(key_we), .key_in(key_in),
    .ctr_we(ctr_we), .ctr_in(ctr_in), .en(en), .cfg_chain(cfg_chain),
    .cfg_op(cfg_op), .busy(busy), .done(done), .ctr_cur(ctr_cur),
    .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
    .din_nbytes(din_nbytes), .dout_valid(dout_valid), .dout_ready(dout_ready),
    .dout_data(dout_data), .core_req(core_req), .core_ack(core_ack),
    .core_key(core_key), .core_blk(core_blk), .core_res(core_res)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [BW-1:0] ks_of(input logic [BW-1:0] k, input logic [BW-1:0] b);
    return k ^ {b[BW-9:0], b[BW-1:BW-8]};
  endfunction

  // Stand-in cipher core: answers three cycles after a request.
  always @(posedge clk) begin
    if (!rst_n) begin
      core_ack <= 1'b0; core_res <= '0; dly <= '0;
    end else if (core_req && !core_ack) begin
      if (dly == 2'd2) begin
        core_ack <= 1'b1; core_res <= ks_of(core_key, core_blk); dly <= '0;
      end else dly <= dly + 2'd1;
    end else core_ack <= 1'b0;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog (all requirements) actual=%0d expected=<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [BW-1:0] pad_mix(input logic [BW-1:0] d, input logic [BW-1:0] k, input int n);
    logic [BW-1:0] r = '0;
    for (int i = 0; i < BW/8; i++)
      if (i < n) r[BW-1-8*i -: 8] = d[BW-1-8*i -: 8] ^ k[BW-1-8*i -: 8];
    return r;
  endfunction

  function automatic logic [BW-1:0] step_ctr(input logic [BW-1:0] c);
    return {c[BW-1:CNTW], c[CNTW-1:0] + CNTW'(1)};
  endfunction

  task automatic chk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic e, input logic [1:0] ch, input logic [1:0] op);
    @(negedge clk); ctl_we = 1; ctl_en = e; ctl_chain = ch; ctl_op = op;
    @(negedge clk); ctl_we = 0; ctl_en = 0;
  endtask

  task automatic write_key(input logic [BW-1:0] k);
    @(negedge clk); key_we = 1; key_in = k;
    @(negedge clk); key_we = 0;
  endtask

  task automatic write_ctr(input logic [BW-1:0] c);
    @(negedge clk); ctr_we = 1; ctr_in = c;
    @(negedge clk); ctr_we = 0;
  endtask

  task automatic run_block(input string req, input logic [BW-1:0] d, input int n,
                           input bit consume, output logic [BW-1:0] res);
    logic [BW-1:0] exp = pad_mix(d, ks_of(key_m, ctr_m), n);
    while (!din_ready) @(negedge clk);
    din_valid = 1; din_data = d; din_nbytes = NBW'(n);
    @(negedge clk); din_valid = 0;
    res = dout_data;
    chk({req, " data"}, dout_data, exp);
    chk("R5 done pulse", {BW{1'b0}} | done, 1);
    chk("R5 en cleared", {BW{1'b0}} | {en, busy}, 0);
    ctr_m = step_ctr(ctr_m);
    chk("R6 counter step", ctr_cur, ctr_m);
    if (consume) begin
      dout_ready = 1; @(negedge clk); dout_ready = 0;
      chk("R5 done one cycle", {BW{1'b0}} | {done, dout_valid}, 0);
    end
  endtask

  task automatic t_reset();
    chk("R10 reset flags", {BW{1'b0}} | {en, busy, done, dout_valid, core_req}, 0);
    chk("R10 reset counter", ctr_cur, 0);
    chk("R10 reset key", core_key, 0);
  endtask

  task automatic t_full();
    logic [BW-1:0] r, d;
    key_m = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
    ctr_m = 128'hf0f1f2f3_f4f5f6f7_f8f9fafb_fcfd0010;
    d     = 128'h00112233_44556677_8899aabb_ccddeeff;
    write_key(key_m); write_ctr(ctr_m);
    write_ctl(1, 2'b10, 2'b00);
    chk("R2 enable accepted", {BW{1'b0}} | en, 1);
    @(negedge clk);
    chk("R3 request", {BW{1'b0}} | {core_req, busy, din_ready}, 3'b110);
    chk("R3 request block", core_blk, ctr_m);
    chk("R3 request key", core_key, key_m);
    run_block("R4 full", d, 16, 1, r);
    // Decrypt: same counter, result fed back.
    write_ctr(128'hf0f1f2f3_f4f5f6f7_f8f9fafb_fcfd0010);
    ctr_m = 128'hf0f1f2f3_f4f5f6f7_f8f9fafb_fcfd0010;
    write_ctl(1, 2'b10, 2'b11);
    run_block("R4 inverse", r, 16, 1, r);
    chk("R4 round trip", r, d);
  endtask

  task automatic t_partial();
    logic [BW-1:0] r;
    write_ctl(1, 2'b10, 2'b10);
    run_block("R7 five bytes", 128'hdeadbeef_01020304_05060708_090a0b0c, 5, 1, r);
    chk("R7 tail zero", r[BW-41:0], 0);
    write_ctl(1, 2'b10, 2'b00);
    run_block("R7 one byte", {BW{1'b1}}, 1, 1, r);
    write_ctl(1, 2'b10, 2'b00);
    run_block("R7 fifteen bytes", 128'h13579bdf_2468ace0_11223344_55667788, 15, 1, r);
    chk("R7 last byte zero", {BW{1'b0}} | r[7:0], 0);
  endtask

  task automatic t_bad_mode();
    write_ctl(1, 2'b10, 2'b01);
    chk("R2 op 01 refused", {BW{1'b0}} | en, 0);
    repeat (3) @(negedge clk);
    chk("R2 no request", {BW{1'b0}} | {core_req, busy}, 0);
    write_ctl(1, 2'b00, 2'b00);
    chk("R2 chain 00 refused", {BW{1'b0}} | en, 0);
    write_ctl(1, 2'b11, 2'b10);
    chk("R2 chain 11 refused", {BW{1'b0}} | {en, core_req}, 0);
  endtask

  task automatic t_locked();
    logic [BW-1:0] r;
    write_ctl(1, 2'b10, 2'b00);
    write_ctr(128'h1);
    write_key(128'h2);
    write_ctl(0, 2'b01, 2'b01);
    chk("R1 counter locked", ctr_cur, ctr_m);
    chk("R1 key locked", core_key, key_m);
    chk("R1 enable kept", {BW{1'b0}} | {en, cfg_chain, cfg_op}, 5'b11000);
    run_block("R1 old settings used", 128'h5a5a5a5a_a5a5a5a5_5a5a5a5a_a5a5a5a5, 16, 1, r);
  endtask

  task automatic t_backpressure();
    logic [BW-1:0] r;
    write_ctl(1, 2'b10, 2'b00);
    run_block("R8 held block", 128'hcafef00d_cafef00d_cafef00d_cafef00d, 16, 0, r);
    repeat (3) @(negedge clk);
    chk("R8 valid held", {BW{1'b0}} | {dout_valid, din_ready}, 2'b10);
    chk("R8 data held", dout_data, r);
    write_ctl(1, 2'b10, 2'b00);
    chk("R8 enable refused", {BW{1'b0}} | {en, core_req}, 0);
    dout_ready = 1; @(negedge clk); dout_ready = 0;
    chk("R8 drained", {BW{1'b0}} | dout_valid, 0);
  endtask

  task automatic t_wrap();
    logic [BW-1:0] r;
    ctr_m = 128'h89abcdef_01234567_76543210_fedcffff;
    write_ctr(ctr_m);
    write_ctl(1, 2'b10, 2'b00);
    run_block("R6 wrap block", 128'h0, 16, 1, r);
    chk("R6 wrap value", ctr_cur, 128'h89abcdef_01234567_76543210_fedc0000);
  endtask

  task automatic t_resume();
    logic [BW-1:0] saved, r, d;
    d = 128'h600dd00d_12345678_9abcdef0_0badf00d;
    saved = ctr_cur;
    chk("R9 readback", saved, ctr_m);
    ctr_m = 128'h77777777_77777777_77777777_77770000;
    write_ctr(ctr_m);
    write_ctl(1, 2'b10, 2'b00);
    run_block("R9 other message", d, 16, 1, r);
    write_ctr(saved);
    ctr_m = saved;
    chk("R9 reloaded", ctr_cur, saved);
    write_ctl(1, 2'b10, 2'b00);
    run_block("R9 resumed", d, 16, 1, r);
    chk("R9 resumed keystream", r, d ^ ks_of(key_m, saved));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_full();
    t_partial();
    t_bad_mode();
    t_locked();
    t_backpressure();
    t_wrap();
    t_resume();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule